// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block collects interrupt sources from a USB controller core and presents them to a processor as one level interrupt line behind a small 32-bit register port. Endpoint events (transmit endpoints and receive endpoints) land in one latched status word. The core's own USB event sources land in a second status word. Each source bit latches on a rising edge of its raw input, whether or not it is enabled. Software acknowledges a bit by writing 1 to it in the status word.

Each status word has an enable mask with two access points. One register turns enable bits on when they are written with 1. The other turns them off when they are written with 1. The interrupt line rises when the block is armed and some enabled status bit is set. Once it has fired, the block disarms. After the sources are serviced, a new event cannot raise the line again until software writes 1 to the end-of-interrupt register. Writing 0 there drops the line at once.

The wrapper also holds a read-only nonzero revision word and a control register whose bit 0 sends a one-cycle reset pulse to the core. It has a status word that reports the core's VBUS-drive level, a PHY control word whose bit 21 (OTG disable) comes out of reset set, and a mode word. Reads are combinational on the address.

Top module: `usbirq_wrap`

## Requirements
- R1: Offset 0x00 reads the constant 32'h5A10_0100. Offsets 0x14 and 0x24 read zero. Every offset outside the map also reads zero.
- R2: The endpoint status word at 0x30 maps transmit endpoint n (0..15) to bit n and receive endpoint n (1..15) to bit 16+n. Bit 16 never sets, because receive endpoint 0 does not exist. A bit latches on the cycle its input rises, whatever the enable is, and an input held high does not latch again after it is cleared.
- R3: The core status word at 0x34 latches core event n (0..8) in bit n on its rising edge. Bits 31:9 read zero.
- R4: Writing a value to 0x30 or 0x34 clears each latched bit written as 1 and leaves the bits written as 0 unchanged.
- R5: An event that rises in the same cycle as a write that clears its bit leaves the bit set.
- R6: A write of 1 bits to 0x38 (endpoint) or 0x3C (core) sets those enable bits. A write of 1 bits to 0x40 (endpoint) or 0x44 (core) clears them. Reads of either register in a pair return the current mask. Endpoint bit 16 and core bits 31:9 stay zero.
- R7: irq_out rises on the second clock edge after an enabled event input rises while the block is armed, and only when some enabled status bit is set. A set status bit whose enable is clear does not raise it.
- R8: Once irq_out has been high, the block is disarmed. After the status is cleared and irq_out falls, new enabled events keep it low until a write of 1 to 0x24. It then rises one edge after that write. A write of 0 to 0x24 forces irq_out low on the write edge and disarms the block.
- R9: Writing 1 in bit 0 of 0x14 drives core_rst_out high for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R10: Bit 0 of offset 0x18 reports vbus_drv_in, registered once. Bits 31:1 read zero.
- R11: The PHY control word at 0xE0 resets to 32'h0020_0000 (bit 21 set) and the mode word at 0xE8 resets to zero. Both are read/write, and phy_ctl_out and mode_out follow them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ep_tx_evt | input | 16 | Raw transmit endpoint event inputs |
| ep_rx_evt | input | 16 | Raw receive endpoint event inputs (bit 0 unused) |
| core_evt | input | 9 | Raw USB core event inputs |
| vbus_drv_in | input | 1 | VBUS-drive level from the core |
| irq_out | output | 1 | Level interrupt to the processor |
| core_rst_out | output | 1 | One-cycle reset pulse to the core |
| phy_ctl_out | output | 32 | PHY control word |
| mode_out | output | 32 | Mode word |

## Verification
The bench sweeps every bit position of both status words. This catches a design that shifts the receive field or latches the missing receive endpoint 0 at bit 16. Such a design reads back a wrong status word or raises the line for a non-existent source. It makes a clear and a fresh event collide in one cycle, where a design that gives the clear priority loses the event. It also holds an input high across a clear, where a level-sensitive latch would set the bit again. It exercises the end-of-interrupt handshake in both directions. A design that re-arms by itself re-asserts the line without the write of 1, and one that ignores the write of 0 keeps the line high.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_REV      = 8'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 8'h14;
  localparam logic [REG_AW-1:0] OFS_VSTAT    = 8'h18;
  localparam logic [REG_AW-1:0] OFS_EOI      = 8'h24;
  localparam logic [REG_AW-1:0] OFS_EP_ST    = 8'h30;
  localparam logic [REG_AW-1:0] OFS_CORE_ST  = 8'h34;
  localparam logic [REG_AW-1:0] OFS_EP_SET   = 8'h38;
  localparam logic [REG_AW-1:0] OFS_CORE_SET = 8'h3C;
  localparam logic [REG_AW-1:0] OFS_EP_CLR   = 8'h40;
  localparam logic [REG_AW-1:0] OFS_CORE_CLR = 8'h44;
  localparam logic [REG_AW-1:0] OFS_PHY      = 8'hE0;
  localparam logic [REG_AW-1:0] OFS_MODE     = 8'hE8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_REV,
    SEL_CTRL,
    SEL_VSTAT,
    SEL_EOI,
    SEL_EP_ST,
    SEL_CORE_ST,
    SEL_EP_EN,
    SEL_CORE_EN,
    SEL_PHY,
    SEL_MODE
  } reg_sel_e;

  typedef struct packed {
    logic st_clr;
    logic en_set;
    logic en_clr;
  } grp_wr_t;

  function automatic reg_sel_e decode_sel(input logic [REG_AW-1:0] a);
    reg_sel_e s;
    unique case (a)
      OFS_REV:                  s = SEL_REV;
      OFS_CTRL:                 s = SEL_CTRL;
      OFS_VSTAT:                s = SEL_VSTAT;
      OFS_EOI:                  s = SEL_EOI;
      OFS_EP_ST:                s = SEL_EP_ST;
      OFS_CORE_ST:              s = SEL_CORE_ST;
      OFS_EP_SET, OFS_EP_CLR:   s = SEL_EP_EN;
      OFS_CORE_SET, OFS_CORE_CLR: s = SEL_CORE_EN;
      OFS_PHY:                  s = SEL_PHY;
      OFS_MODE:                 s = SEL_MODE;
      default:                  s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/usbirq_srcgrp.sv
module usbirq_srcgrp #(
  parameter int           W     = 9,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] wdata_i,
  input  usbirq_pkg::grp_wr_t wr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] evt_q_o,
  output logic         pend_o
);

  logic [W-1:0] evt_q;
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] rise;
  logic [W-1:0] clr_mask;
  logic         stat_ce;
  logic         en_ce;

  always_comb begin
    rise     = evt_i & ~evt_q;
    clr_mask = wr_i.st_clr ? wdata_i : '0;
    // a new rise wins over an acknowledge of the same bit
    stat_d   = ((stat_q & ~clr_mask) | rise) & VALID;
    stat_ce  = (|rise) | wr_i.st_clr;
  end

  always_comb begin
    en_d = en_q;
    if (wr_i.en_set) en_d = en_d | wdata_i;
    if (wr_i.en_clr) en_d = en_d & ~wdata_i;
    en_d  = en_d & VALID;
    en_ce = wr_i.en_set | wr_i.en_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign stat_o  = stat_q;
  assign en_o    = en_q;
  assign evt_q_o = evt_q;
  assign pend_o  = |(stat_q & en_q);

endmodule

// File: rtl/usbirq_arm.sv
module usbirq_arm #(
  parameter int NUM_GRP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] pend_i,
  input  logic               eoi_wr_i,
  input  logic               eoi_val_i,
  output logic               irq_o,
  output logic               armed_o
);

  logic any_pend;
  logic irq_q, irq_d;
  logic armed_q, armed_d;

  always_comb begin
    any_pend = |pend_i;
    if (eoi_wr_i && !eoi_val_i) begin
      irq_d = 1'b0;
    end else begin
      // once raised the line holds until sources drain; raising needs arm
      irq_d = any_pend & (irq_q | armed_q);
    end
    if (eoi_wr_i) begin
      armed_d = eoi_val_i;
    end else if (irq_q) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq_q   <= irq_d;
      armed_q <= armed_d;
    end
  end

  assign irq_o   = irq_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/usbirq_ctlregs.sv
module usbirq_ctlregs #(
  parameter int          DW       = 32,
  parameter int          RST_BIT  = 0,
  parameter logic [DW-1:0] PHY_RST = 32'h0020_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctrl_wr_i,
  input  logic          phy_wr_i,
  input  logic          mode_wr_i,
  input  logic          vbus_i,
  output logic          core_rst_o,
  output logic          vbus_q_o,
  output logic [DW-1:0] phy_o,
  output logic [DW-1:0] mode_o
);

  logic          rst_pulse_q, rst_pulse_d;
  logic          vbus_q;
  logic [DW-1:0] phy_q;
  logic [DW-1:0] mode_q;

  always_comb begin
    rst_pulse_d = ctrl_wr_i & wdata_i[RST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse_q <= 1'b0;
      vbus_q      <= 1'b0;
    end else begin
      rst_pulse_q <= rst_pulse_d;
      vbus_q      <= vbus_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q <= PHY_RST;
    end else if (phy_wr_i) begin
      phy_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr_i) begin
      mode_q <= wdata_i;
    end
  end

  assign core_rst_o = rst_pulse_q;
  assign vbus_q_o   = vbus_q;
  assign phy_o      = phy_q;
  assign mode_o     = mode_q;

endmodule

// File: rtl/usbirq_wrap.sv
module usbirq_wrap #(
  parameter int          NUM_EP      = 16,
  parameter int          CORE_W      = 9,
  parameter logic [31:0] REVISION    = 32'h5A10_0100,
  parameter int          OTG_DIS_BIT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EP-1:0] ep_tx_evt,
  input  logic [NUM_EP-1:0] ep_rx_evt,
  input  logic [CORE_W-1:0] core_evt,
  input  logic              vbus_drv_in,
  output logic              irq_out,
  output logic              core_rst_out,
  output logic [31:0]       phy_ctl_out,
  output logic [31:0]       mode_out
);
  import usbirq_pkg::*;

  localparam int              EP_W     = 2 * NUM_EP;
  localparam logic [EP_W-1:0] EP_VALID = {{(NUM_EP-1){1'b1}}, 1'b0, {NUM_EP{1'b1}}};
  localparam logic [31:0]     PHY_RST  = 32'(1) << OTG_DIS_BIT;
  localparam int              NUM_GRP  = 2;

  reg_sel_e          sel;
  grp_wr_t           ep_wr, core_wr;
  logic              eoi_wr, ctrl_wr, phy_wr, mode_wr;
  logic [EP_W-1:0]   ep_evt;
  logic [EP_W-1:0]   ep_stat, ep_en, ep_evt_q;
  logic [CORE_W-1:0] core_stat, core_en, core_evt_q;
  logic [NUM_GRP-1:0] pend;
  logic              armed;
  logic              vbus_q;

  always_comb begin
    sel            = decode_sel(reg_addr);
    ep_wr.st_clr   = reg_wr && (reg_addr == OFS_EP_ST);
    ep_wr.en_set   = reg_wr && (reg_addr == OFS_EP_SET);
    ep_wr.en_clr   = reg_wr && (reg_addr == OFS_EP_CLR);
    core_wr.st_clr = reg_wr && (reg_addr == OFS_CORE_ST);
    core_wr.en_set = reg_wr && (reg_addr == OFS_CORE_SET);
    core_wr.en_clr = reg_wr && (reg_addr == OFS_CORE_CLR);
    eoi_wr         = reg_wr && (sel == SEL_EOI);
    ctrl_wr        = reg_wr && (sel == SEL_CTRL);
    phy_wr         = reg_wr && (sel == SEL_PHY);
    mode_wr        = reg_wr && (sel == SEL_MODE);
    ep_evt         = {ep_rx_evt, ep_tx_evt};
  end

  usbirq_srcgrp #(
    .W     (EP_W),
    .VALID (EP_VALID)
  ) u_ep_grp (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (ep_evt),
    .wdata_i (reg_wdata[EP_W-1:0]),
    .wr_i    (ep_wr),
    .stat_o  (ep_stat),
    .en_o    (ep_en),
    .evt_q_o (ep_evt_q),
    .pend_o  (pend[0])
  );

  usbirq_srcgrp #(
    .W     (CORE_W),
    .VALID ({CORE_W{1'b1}})
  ) u_core_grp (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (core_evt),
    .wdata_i (reg_wdata[CORE_W-1:0]),
    .wr_i    (core_wr),
    .stat_o  (core_stat),
    .en_o    (core_en),
    .evt_q_o (core_evt_q),
    .pend_o  (pend[1])
  );

  usbirq_arm #(
    .NUM_GRP (NUM_GRP)
  ) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .eoi_wr_i  (eoi_wr),
    .eoi_val_i (reg_wdata[0]),
    .irq_o     (irq_out),
    .armed_o   (armed)
  );

  usbirq_ctlregs #(
    .DW      (32),
    .RST_BIT (0),
    .PHY_RST (PHY_RST)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdata_i    (reg_wdata),
    .ctrl_wr_i  (ctrl_wr),
    .phy_wr_i   (phy_wr),
    .mode_wr_i  (mode_wr),
    .vbus_i     (vbus_drv_in),
    .core_rst_o (core_rst_out),
    .vbus_q_o   (vbus_q),
    .phy_o      (phy_ctl_out),
    .mode_o     (mode_out)
  );

  always_comb begin
    unique case (sel)
      SEL_REV:     reg_rdata = REVISION;
      SEL_VSTAT:   reg_rdata = {31'd0, vbus_q};
      SEL_EP_ST:   reg_rdata = 32'(ep_stat);
      SEL_CORE_ST: reg_rdata = 32'(core_stat);
      SEL_EP_EN:   reg_rdata = 32'(ep_en);
      SEL_CORE_EN: reg_rdata = 32'(core_en);
      SEL_PHY:     reg_rdata = phy_ctl_out;
      SEL_MODE:    reg_rdata = mode_out;
      default:     reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/usbirq_chk.sv
module usbirq_chk #(
  parameter int EP_W   = 32,
  parameter int CORE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [CORE_W-1:0] core_evt,
  input logic [CORE_W-1:0] core_evt_q,
  input logic [CORE_W-1:0] core_stat,
  input logic [CORE_W-1:0] core_en,
  input logic [EP_W-1:0]   ep_stat,
  input logic [EP_W-1:0]   ep_en,
  input logic              armed,
  input logic              irq_out,
  input logic              core_rst_out
);

  logic [CORE_W-1:0] rise_now;
  logic              pend_now;
  logic              core_clr_wr;
  logic              eoi_wr;
  logic              ctrl_go;

  always_comb begin
    rise_now    = core_evt & ~core_evt_q;
    pend_now    = (|(ep_stat & ep_en)) | (|(core_stat & core_en));
    core_clr_wr = reg_wr && (reg_addr == 8'h34);
    eoi_wr      = reg_wr && (reg_addr == 8'h24);
    ctrl_go     = reg_wr && (reg_addr == 8'h14) && reg_wdata[0];
  end

  // R3 and R5: every rising core input is latched on that edge
  assert_latch_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((core_stat & $past(rise_now)) == $past(rise_now)));

  // R4: acknowledged bits without a fresh rise are gone after the write
  assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_clr_wr |=> ((core_stat & $past(reg_wdata[CORE_W-1:0] & ~rise_now)) == '0));

  // R7: the line is only high when an enabled source was pending
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(pend_now));

  // R8: firing disarms unless an end-of-interrupt write coincides
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_wr) |=> !armed);

  // R8: end-of-interrupt 0 drops the line
  assert_eoi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !reg_wdata[0]) |=> !irq_out);

  // R9: reset pulse only follows a control write with bit 0 set
  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_out |-> $past(ctrl_go));

endmodule

bind usbirq_wrap usbirq_chk #(
  .EP_W   (EP_W),
  .CORE_W (CORE_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .core_evt     (core_evt),
  .core_evt_q   (core_evt_q),
  .core_stat    (core_stat),
  .core_en      (core_en),
  .ep_stat      (ep_stat),
  .ep_en        (ep_en),
  .armed        (armed),
  .irq_out      (irq_out),
  .core_rst_out (core_rst_out)
);

// File: tb/usbirq_wrap_tb_top.sv
module usbirq_wrap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] ep_tx_evt;
  logic [15:0] ep_rx_evt;
  logic [8:0]  core_evt;
  logic        vbus_drv_in;
  logic        irq_out;
  logic        core_rst_out;
  logic [31:0] phy_ctl_out;
  logic [31:0] mode_out;

  int n_chk;
  int n_err;
  bit done;

  usbirq_wrap dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ep_tx_evt    (ep_tx_evt),
    .ep_rx_evt    (ep_rx_evt),
    .core_evt     (core_evt),
    .vbus_drv_in  (vbus_drv_in),
    .irq_out      (irq_out),
    .core_rst_out (core_rst_out),
    .phy_ctl_out  (phy_ctl_out),
    .mode_out     (mode_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_ep(input int bitpos);
    @(negedge clk);
    if (bitpos < 16) ep_tx_evt = 16'(1) << bitpos;
    else             ep_rx_evt = 16'(1) << (bitpos - 16);
    @(negedge clk);
    ep_tx_evt = '0;
    ep_rx_evt = '0;
  endtask

  task automatic pulse_core(input int bitpos);
    @(negedge clk);
    core_evt = 9'(1) << bitpos;
    @(negedge clk);
    core_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    ep_tx_evt = '0; ep_rx_evt = '0; core_evt = '0; vbus_drv_in = 1'b0;
    idle(4);
    rst_n = 1'b1;

    // reset state
    chk("R7 irq after reset", {31'd0, irq_out}, 32'd0);
    chk("R9 rst pulse after reset", {31'd0, core_rst_out}, 32'd0);
    chk("R11 phy out reset", phy_ctl_out, 32'h0020_0000);
    chk("R11 mode out reset", mode_out, 32'd0);
    rd(8'h30, d); chk("R2 ep status reset", d, 32'd0);
    rd(8'h34, d); chk("R3 core status reset", d, 32'd0);
    rd(8'h38, d); chk("R6 ep enable reset", d, 32'd0);
    rd(8'h44, d); chk("R6 core enable reset", d, 32'd0);

    // R1 revision and unused offsets
    rd(8'h00, d); chk("R1 revision", d, 32'h5A10_0100);
    rd(8'h14, d); chk("R1 control reads zero", d, 32'd0);
    rd(8'h24, d); chk("R1 eoi reads zero", d, 32'd0);
    for (int a = 4; a < 256; a += 4) begin
      if (!(a inside {8'h14, 8'h18, 8'h24, 8'h30, 8'h34, 8'h38, 8'h3C,
                      8'h40, 8'h44, 8'hE0, 8'hE8})) begin
        rd(8'(a), d); chk("R1 unused offset", d, 32'd0);
      end
    end

    // R6 enable set/clear readback
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); chk("R6 ep enable via set", d, 32'hFFFE_FFFF);
    rd(8'h40, d); chk("R6 ep enable via clr", d, 32'hFFFE_FFFF);
    wr(8'h40, 32'h0000_00F0);
    rd(8'h38, d); chk("R6 ep enable after clear", d, 32'hFFFE_FF0F);
    wr(8'h38, 32'h0000_00F0);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, d); chk("R6 core enable via set", d, 32'h0000_01FF);
    rd(8'h44, d); chk("R6 core enable via clr", d, 32'h0000_01FF);

    // R2 R7 R8 sweep over endpoint bit positions
    for (int i = 0; i < 32; i++) begin
      exp = (i == 16) ? 32'd0 : (32'd1 << i);
      pulse_ep(i);
      rd(8'h30, d); chk("R2 ep status bit latch", d, exp);
      chk("R7 irq for ep bit", {31'd0, irq_out}, {31'd0, (i != 16)});
      wr(8'h30, 32'd1 << i);
      rd(8'h30, d); chk("R4 ep status cleared", d, 32'd0);
      chk("R7 irq drops after clear", {31'd0, irq_out}, 32'd0);
      wr(8'h24, 32'd1);
    end

    // R3 sweep over core bit positions
    for (int i = 0; i < 9; i++) begin
      pulse_core(i);
      rd(8'h34, d); chk("R3 core status bit latch", d, 32'd1 << i);
      chk("R7 irq for core bit", {31'd0, irq_out}, 32'd1);
      wr(8'h34, 32'd1 << i);
      rd(8'h34, d); chk("R4 core status cleared", d, 32'd0);
      wr(8'h24, 32'd1);
    end

    // R4 partial acknowledge, disabled sources
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    pulse_core(1); pulse_core(3);
    rd(8'h34, d); chk("R3 two bits latched without enable", d, 32'h0000_000A);
    chk("R7 no irq when disabled", {31'd0, irq_out}, 32'd0);
    wr(8'h34, 32'h0000_0002);
    rd(8'h34, d); chk("R4 only written bit clears", d, 32'h0000_0008);

    // R7 enable on a different bit does not fire, enabling the set bit does
    wr(8'h3C, 32'h0000_0001);
    idle(2);
    chk("R7 mismatched enable no irq", {31'd0, irq_out}, 32'd0);
    wr(8'h3C, 32'h0000_0008);
    idle(1);
    chk("R7 irq after enabling pending bit", {31'd0, irq_out}, 32'd1);

    // R8 disarm and end-of-interrupt handshake
    wr(8'h34, 32'h0000_0008);
    idle(1);
    chk("R8 irq low after service", {31'd0, irq_out}, 32'd0);
    pulse_core(0);
    idle(3);
    chk("R8 stays low until eoi", {31'd0, irq_out}, 32'd0);
    wr(8'h24, 32'd1);
    idle(1);
    chk("R8 irq after eoi one", {31'd0, irq_out}, 32'd1);
    wr(8'h24, 32'd0);
    chk("R8 eoi zero drops irq", {31'd0, irq_out}, 32'd0);
    idle(2);
    chk("R8 stays low after eoi zero", {31'd0, irq_out}, 32'd0);
    wr(8'h34, 32'h0000_01FF);
    wr(8'h24, 32'd1);

    // R5 event colliding with its acknowledge
    pulse_core(2);
    @(negedge clk);
    reg_addr = 8'h34; reg_wdata = 32'h0000_0004; reg_wr = 1'b1;
    core_evt = 9'h004;
    @(negedge clk);
    reg_wr = 1'b0; core_evt = '0;
    rd(8'h34, d); chk("R5 collision keeps bit", d, 32'h0000_0004);

    // R2 held input does not relatch
    @(negedge clk); core_evt = 9'h010;
    idle(1);
    wr(8'h34, 32'h0000_0014);
    idle(2);
    rd(8'h34, d); chk("R3 held input not relatched", d, 32'd0);
    core_evt = '0;
    @(negedge clk); ep_rx_evt = 16'h0001;
    idle(2);
    ep_rx_evt = '0;
    rd(8'h30, d); chk("R2 rx endpoint 0 absent", d, 32'd0);
    wr(8'h24, 32'd1);

    // R9 core reset pulse
    @(negedge clk);
    reg_addr = 8'h14; reg_wdata = 32'd1; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 pulse high after write", {31'd0, core_rst_out}, 32'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, core_rst_out}, 32'd0);
    wr(8'h14, 32'h0000_0002);
    chk("R9 no pulse for bit 0 clear", {31'd0, core_rst_out}, 32'd0);

    // R10 VBUS drive level
    vbus_drv_in = 1'b1;
    rd(8'h18, d); chk("R10 vbus high", d, 32'd1);
    vbus_drv_in = 1'b0;
    rd(8'h18, d); chk("R10 vbus low", d, 32'd0);

    // R11 PHY and mode words
    rd(8'hE0, d); chk("R11 phy reset value", d, 32'h0020_0000);
    wr(8'hE0, 32'h0000_0000);
    rd(8'hE0, d); chk("R11 phy written", d, 32'd0);
    chk("R11 phy out follows", phy_ctl_out, 32'd0);
    wr(8'hE8, 32'hA5C3_0F11);
    rd(8'hE8, d); chk("R11 mode written", d, 32'hA5C3_0F11);
    chk("R11 mode out follows", mode_out, 32'hA5C3_0F11);

    finish_run();
  end

endmodule